// File: doc/BRIEF.md
# Stepped Random Modulation Generator

This block produces a staircase control word for a stepped flanger or phaser sweep. A 24-bit pseudo-random shift register is not advanced every sample. It moves one step only when a free-running downward ramp wraps. Between wraps it holds its word, so the modulation target jumps to a new random position and then stays flat for one ramp period.

The ramp is a phase accumulator. It is decremented once per sample strobe by the square of an unsigned rate control, so the rate control has a smooth taper. When a subtraction borrows, the ramp has wrapped. On that wrap the shift register advances and a one-cycle step pulse marks the new value. At reset the register is loaded from an external seed with one bit forced high, so the state is never all zeros.

Top module: `step_mod_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `rand_o` becomes `seed_i | 24'h001000`, `step_o` becomes 0 and the ramp phase becomes 0.
- R2: One advance maps state s to `{s[0]^s[1]^s[2]^s[7], s[23:1]}`. This is a right shift by one, with the feedback bit written into bit 23.
- R3: `rand_o` changes only on an advance and holds its value in every other cycle.
- R4: Each `sample_en` cycle subtracts `rate_i*rate_i` (modulo 2^24) from the ramp. An advance happens exactly when that subtraction borrows. The first strobe after reset with a nonzero rate therefore advances, and N strobes give ceil(N*rate_i^2 / 2^24) advances.
- R5: `step_o` is high for the one cycle after each advancing strobe, in the same cycle that `rand_o` shows the new value. Consecutive strobes that both wrap give consecutive pulses.
- R6: Cycles without `sample_en` leave both the ramp phase and `rand_o` unchanged.
- R7: With `rate_i` equal to 0, no advance ever happens.
- R8: `rand_o` is never zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Sample strobe; steps the ramp once |
| seed_i | input | 24 | Seed word loaded during reset |
| rate_i | input | 12 | Unsigned rate control; ramp step is its square |
| rand_o | output | 24 | Held pseudo-random modulation word |
| step_o | output | 1 | One-cycle pulse when a new word is taken |

## Verification
The table-driven runs pair different seeds with rates 0, 512, 1024, 2048 and 4095. Each run counts the step pulses over a fixed number of strobes. A zero rate separates a dead ramp from a running one. The power-of-two rates separate exact divisions from rounding up. The near-full-scale rate separates correct borrow detection from a sign or width slip. Every new word is compared with an independent model of the shift register, which catches wrong taps or a wrong shift direction. Directed tests cover strobes on every cycle (back-to-back pulses), long gaps with no strobe, a zero seed, and a reset in the middle of a run that must zero the ramp again.

// File: rtl/stepmod_pkg.sv
package stepmod_pkg;
    localparam int unsigned WORD_W  = 24;
    localparam int unsigned TAP_0   = 0;
    localparam int unsigned TAP_1   = 1;
    localparam int unsigned TAP_2   = 2;
    localparam int unsigned TAP_3   = 7;
    localparam logic [WORD_W-1:0] SEED_FORCE = 24'h001000;

    typedef logic [WORD_W-1:0] word_t;

    // one right-shift advance with the feedback bit entering at the top
    function automatic word_t word_advance(input word_t s);
        logic fb;
        fb = s[TAP_0] ^ s[TAP_1] ^ s[TAP_2] ^ s[TAP_3];
        return {fb, s[WORD_W-1:1]};
    endfunction
endpackage

// File: rtl/rate_square.sv
module rate_square #(
    parameter int unsigned RATE_W  = 12,
    parameter int unsigned PHASE_W = 24
) (
    input  logic [RATE_W-1:0]  rate_i,
    output logic [PHASE_W-1:0] inc_o
);
    localparam int unsigned SQ_W = 2 * RATE_W;

    logic [SQ_W-1:0] sq;
    assign sq = SQ_W'(rate_i) * SQ_W'(rate_i);

    generate
        if (SQ_W < PHASE_W) begin : g_pad
            assign inc_o = {{(PHASE_W - SQ_W){1'b0}}, sq};
        end else begin : g_trim
            assign inc_o = sq[PHASE_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ramp_wrap.sv
module ramp_wrap #(
    parameter int unsigned PHASE_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_en,
    input  logic [PHASE_W-1:0] inc_i,
    output logic               wrap_o
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
    } ramp_t;

    ramp_t ramp_d, ramp_q;
    logic [PHASE_W:0] diff;

    always_comb begin
        ramp_d = ramp_q;
        diff   = {1'b0, ramp_q.phase} - {1'b0, inc_i};
        wrap_o = 1'b0;
        if (sample_en) begin
            ramp_d.phase = diff[PHASE_W-1:0];
            wrap_o       = diff[PHASE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ramp_q <= '0;
        else     ramp_q <= ramp_d;
    end

    // R6
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(ramp_q.phase));
    // R7
    zero_rate_still_chk: assert property (@(posedge clk) disable iff (rst)
        (inc_i == '0) |-> !wrap_o);
    // R4
    zero_phase_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_en && inc_i != '0 && ramp_q.phase == '0) |-> wrap_o);
endmodule

// File: rtl/word_hold.sv
module word_hold
    import stepmod_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t seed_i,
    input  logic  adv_i,
    output word_t word_o
);
    typedef struct packed {
        word_t state;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (adv_i) hold_d.state = word_advance(hold_q.state);
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q.state <= seed_i | SEED_FORCE;
        else     hold_q       <= hold_d;
    end

    assign word_o = hold_q.state;

    // R3
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(hold_q.state));
    // R2
    shift_right_chk: assert property (@(posedge clk) disable iff (rst)
        adv_i |=> hold_q.state[WORD_W-2:0] == $past(hold_q.state[WORD_W-1:1]));
    // R8
    never_zero_chk: assert property (@(posedge clk) disable iff (rst)
        hold_q.state != '0);
endmodule

// File: rtl/step_mod_gen.sv
module step_mod_gen #(
    parameter int unsigned RATE_W  = 12,
    parameter int unsigned PHASE_W = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sample_en,
    input  logic [23:0] seed_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic [23:0] rand_o,
    output logic        step_o
);
    import stepmod_pkg::*;

    typedef struct packed {
        logic step;
    } top_t;

    top_t top_d, top_q;
    logic [PHASE_W-1:0] inc;
    logic wrap;
    word_t word;

    rate_square #(.RATE_W(RATE_W), .PHASE_W(PHASE_W)) i_rate_square (
        .rate_i (rate_i),
        .inc_o  (inc)
    );

    ramp_wrap #(.PHASE_W(PHASE_W)) i_ramp_wrap (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .inc_i     (inc),
        .wrap_o    (wrap)
    );

    word_hold i_word_hold (
        .clk    (clk),
        .rst    (rst),
        .seed_i (seed_i),
        .adv_i  (wrap),
        .word_o (word)
    );

    always_comb begin
        top_d      = top_q;
        top_d.step = wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) top_q <= '0;
        else     top_q <= top_d;
    end

    assign rand_o = word;
    assign step_o = top_q.step;

    // R5
    step_marks_change_chk: assert property (@(posedge clk) disable iff (rst)
        step_o |-> !$stable(rand_o));
    // R3
    quiet_means_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_o |-> $stable(rand_o));
endmodule

// File: tb/test_step_mod_gen.sv
module test_step_mod_gen;
    localparam int CLK_P = 10;
    localparam int NROW  = 5;
    localparam logic [23:0] T_SEED [NROW] = '{24'h000000, 24'h000001, 24'hABCDEF, 24'h800000, 24'h00F00F};
    localparam logic [11:0] T_RATE [NROW] = '{12'd0, 12'd4095, 12'd2048, 12'd1024, 12'd512};
    localparam int          T_NS   [NROW] = '{50, 20, 40, 100, 300};
    localparam int          T_EXP  [NROW] = '{0, 20, 10, 7, 5};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_en = 1'b0;
    logic [23:0] seed = '0;
    logic [11:0] rate = '0;
    logic [23:0] rand_w;
    logic step_w;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    step_mod_gen i_step_mod_gen (
        .clk(clk), .rst(rst), .sample_en(sample_en), .seed_i(seed),
        .rate_i(rate), .rand_o(rand_w), .step_o(step_w)
    );

    function automatic logic [23:0] ref_next(input logic [23:0] s);
        return {^{s[7], s[2], s[1], s[0]}, s[23:1]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    task automatic do_reset(input logic [23:0] s, input logic [11:0] r);
        rst = 1'b1; seed = s; rate = r; sample_en = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        chk(rand_w == (s | 24'h001000), "R1 seed load", rand_w, s | 24'h001000);
        chk(step_w == 1'b0, "R1 step low", {23'd0, step_w}, 24'd0);
    endtask

    // one strobe, then one idle cycle checking hold
    task automatic strobe(inout logic [23:0] model, inout int cnt);
        logic [23:0] prev;
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
        if (step_w) begin
            cnt++;
            model = ref_next(model);
            chk(rand_w == model, "R2 next word", rand_w, model);
        end else begin
            chk(rand_w == model, "R3 hold no wrap", rand_w, model);
        end
        prev = rand_w;
        @(negedge clk);
        chk(step_w == 1'b0 && rand_w == prev, "R5 single pulse / R6 hold", rand_w, prev);
    endtask

    initial begin
        logic [23:0] m;
        int c;
        @(negedge clk);
        for (int k = 0; k < NROW; k++) begin
            do_reset(T_SEED[k], T_RATE[k]);
            m = T_SEED[k] | 24'h001000;
            c = 0;
            for (int i = 0; i < T_NS[k]; i++) strobe(m, c);
            // R4 step count; row 0 covers R7
            chk(c == T_EXP[k], "R4 R7 step count", 24'(c), 24'(T_EXP[k]));
        end

        // R5 back-to-back wraps
        do_reset(24'h000005, 12'd4095);
        m = 24'h001005;
        sample_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            m = ref_next(m);
            chk(step_w == 1'b1, "R5 consecutive pulse", {23'd0, step_w}, 24'd1);
            chk(rand_w == m, "R5 R2 word each pulse", rand_w, m);
        end
        sample_en = 1'b0;
        @(negedge clk);
        chk(step_w == 1'b0, "R5 pulse ends", {23'd0, step_w}, 24'd0);

        // R6 no strobe, ramp held at zero
        do_reset(24'h0A0A0A, 12'd2048);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(step_w == 1'b0 && rand_w == 24'h0A1A0A, "R6 idle hold", rand_w, 24'h0A1A0A);
        end
        m = 24'h0A1A0A; c = 0;
        strobe(m, c);
        chk(c == 1, "R6 R4 ramp kept zero", 24'(c), 24'd1);

        // R8 zero seed
        do_reset(24'h000000, 12'd0);
        chk(rand_w != 24'd0, "R8 nonzero", rand_w, 24'h001000);

        // R1 mid-run reset zeroes ramp
        do_reset(24'h123456, 12'd1024);
        m = 24'h123456 | 24'h001000; c = 0;
        for (int i = 0; i < 5; i++) strobe(m, c);
        do_reset(24'h00FF00, 12'd1024);
        m = 24'h00FF00 | 24'h001000; c = 0;
        strobe(m, c);
        chk(c == 1, "R1 ramp zeroed by reset", 24'(c), 24'd1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule